// File: doc/BRIEF.md
# Rotating register frame mapper

This block sits in front of a windowed integer register file of 128 entries, each 64 bits wide. It converts the logical register number that an instruction names into the physical index of the storage entry. Registers 0 to 31 are global and do not move. Registers 32 to 127 form a pool of 96 entries that is used as a ring. Each procedure owns a window of that ring, and inside every window the first register is called 32, wherever the window physically starts. The storage array and the backing memory are not part of this block.

A window has a size and a local part. The rest of the window is the output part. On a call, the callee's window starts where the caller's output part starts, so values that the caller leaves in its outputs show up as the callee's first registers without any copy. The caller's size and local count are pushed on a small marker stack, and a return pops them. The pool holds only 96 entries. When a new window would not fit next to the caller windows still held in the ring, the block asks an external agent to save the oldest entries to memory. When a return finds that part of the caller's locals was saved earlier, the block asks for them to be loaded back. The return takes effect only when that request is acknowledged.

Top module: `frame_mapper`

## Requirements
- R1: A logical number below 32 maps to the same physical number and never raises `rdIllegal`.
- R2: A logical number L of 32 or above maps to 32 + ((base + L − 32) mod 96). After reset, base is 0 and the window size is 0.
- R3: For L of 32 or above, `rdIllegal` is 1 exactly when L − 32 is at least the current window size.
- R4: Command op encodings are 0 for no-op, 1 for alloc, 2 for call and 3 for return. Alloc sets the window size to `cmdSize` and the local count to size minus `cmdOut`. A size above 96 is taken as 96, and an output count above the size is taken as the size.
- R5: Call sets the new base to old base + old locals (mod 96), sets the window size to the old output count and the local count to 0, and pushes the old size and local count. Caller register 32+locals+k and callee register 32+k reach the same physical entry.
- R6: If the locals still held in the ring plus a new alloc size exceed 96, the block raises `memReq` with `memFill`=0 in the cycle after the alloc. `memCount` is the excess and `memBase` is the physical index of the oldest held entry. The request stays up until `memAck`.
- R7: A return whose caller locals are all still in the ring restores the caller's base, size and local count at once and raises no request.
- R8: A return whose caller locals are partly saved raises `memReq` with `memFill`=1. `memCount` is the number of missing entries and `memBase` is 32 + the caller base. The mapping stays unchanged until `memAck`. While a request is up, `cmdReady` is 0 and commands are ignored.
- R9: A return with an empty marker stack is ignored, and so is a call when the stack holds `STACK_DEPTH` markers.
- R10: Out of reset, `cmdReady` is 1 and `memReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 no-op, 1 alloc, 2 call, 3 return |
| cmdSize | input | 7 | Alloc window size |
| cmdOut | input | 7 | Alloc output count |
| cmdReady | output | 1 | Commands are accepted |
| rdLogical | input | 7 | Logical register number |
| rdPhys | output | 7 | Physical register index |
| rdIllegal | output | 1 | Logical number lies beyond the window |
| memReq | output | 1 | Save or load request |
| memFill | output | 1 | 1 for load, 0 for save |
| memBase | output | 7 | First physical entry of the request |
| memCount | output | 7 | Number of entries in the request |
| memAck | input | 1 | Request done |

## Verification
The hardest case to reach is a return that needs a load. It requires a deep call chain that overflows the ring, a save of the oldest caller's locals, and then returns back past the part of the ring that is still held. The stimulus builds three nested windows of 20, 60 and 40 entries, so the third alloc saves nine entries. The first return is then served straight from the ring. The second return needs exactly those nine entries back, and the bench probes the mapping while that load is still pending. A call issued during the save, and a call against a full marker stack, are both checked through later mappings and pops.

// File: rtl/frame_pkg.sv
package frame_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ALLOC = 2'd1,
    OP_CALL  = 2'd2,
    OP_RET   = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic alloc;
    logic call;
    logic ret;
    logic retFill;
    logic spillDone;
    logic fillDone;
    logic busy;
  } frame_strobe_t;
endpackage

// File: rtl/frame_dp.sv
module frame_dp
  import frame_pkg::*;
#(
  parameter int NUM_REGS    = 128,
  parameter int STATIC_REGS = 32,
  parameter int STACK_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  frame_strobe_t               stb,
  input  logic [$clog2(NUM_REGS)-1:0] cmdSize,
  input  logic [$clog2(NUM_REGS)-1:0] cmdOut,
  input  logic [$clog2(NUM_REGS)-1:0] rdLogical,
  output logic [$clog2(NUM_REGS)-1:0] rdPhys,
  output logic                        rdIllegal,
  output logic                        allocOver,
  output logic                        retNeedFill,
  output logic                        stkEmpty,
  output logic                        stkFull,
  output logic [$clog2(NUM_REGS)-1:0] memBase,
  output logic [$clog2(NUM_REGS)-1:0] memCount
);
  localparam int POOL = NUM_REGS - STATIC_REGS;
  localparam int LW   = $clog2(NUM_REGS);
  localparam int CW   = LW + 1;
  localparam int IW   = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int SPW  = $clog2(STACK_DEPTH + 1);
  localparam logic [CW-1:0] POOL_C = CW'(POOL);
  localparam logic [CW-1:0] STAT_C = CW'(STATIC_REGS);

  logic [CW-1:0] curBase, curSof, curSol, dirty;
  logic [CW-1:0] stkSof [STACK_DEPTH];
  logic [CW-1:0] stkSol [STACK_DEPTH];
  logic [SPW-1:0] stkPtr;

  function automatic logic [CW-1:0] wrapAdd(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW-1:0] s;
    s = a + b;
    return (s >= POOL_C) ? s - POOL_C : s;
  endfunction

  function automatic logic [CW-1:0] wrapSub(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a >= b) ? a - b : a + POOL_C - b;
  endfunction

  logic [CW-1:0] sizeEff, outEff, solNew, needSum, topSof, topSol, callerBase, oldest, offset;
  logic [IW-1:0] topIdx;

  always_comb begin
    sizeEff     = ({1'b0, cmdSize} > POOL_C) ? POOL_C : {1'b0, cmdSize};
    outEff      = ({1'b0, cmdOut} > sizeEff) ? sizeEff : {1'b0, cmdOut};
    solNew      = sizeEff - outEff;
    needSum     = dirty + sizeEff;
    allocOver   = needSum > POOL_C;
    topIdx      = (stkPtr == '0) ? '0 : IW'(stkPtr - 1'b1);
    topSof      = stkSof[topIdx];
    topSol      = stkSol[topIdx];
    retNeedFill = topSol > dirty;
    callerBase  = wrapSub(curBase, topSol);
    oldest      = wrapSub(curBase, dirty);
    stkEmpty    = (stkPtr == '0);
    stkFull     = (stkPtr == SPW'(STACK_DEPTH));
    offset      = {1'b0, rdLogical} - STAT_C;
    if ({1'b0, rdLogical} < STAT_C) begin
      rdPhys    = rdLogical;
      rdIllegal = 1'b0;
    end else begin
      rdPhys    = LW'(STAT_C + wrapAdd(curBase, offset));
      rdIllegal = offset >= curSof;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBase  <= '0;
      curSof   <= '0;
      curSol   <= '0;
      dirty    <= '0;
      stkPtr   <= '0;
      memBase  <= '0;
      memCount <= '0;
    end else begin
      if (stb.alloc) begin
        curSof <= sizeEff;
        curSol <= solNew;
        if (allocOver) begin
          memBase  <= LW'(STAT_C + oldest);
          memCount <= LW'(needSum - POOL_C);
        end
      end
      if (stb.call) begin
        stkPtr  <= stkPtr + 1'b1;
        curBase <= wrapAdd(curBase, curSol);
        curSof  <= curSof - curSol;
        curSol  <= '0;
        dirty   <= dirty + curSol;
      end
      if (stb.retFill) begin
        memBase  <= LW'(STAT_C + callerBase);
        memCount <= LW'(topSol - dirty);
      end
      if (stb.ret || stb.fillDone) begin
        stkPtr  <= stkPtr - 1'b1;
        curBase <= callerBase;
        curSof  <= topSof;
        curSol  <= topSol;
        dirty   <= stb.fillDone ? '0 : dirty - topSol;
      end
      if (stb.spillDone) dirty <= dirty - CW'(memCount);
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && stb.call) begin
      stkSof[IW'(stkPtr)] <= curSof;
      stkSol[IW'(stkPtr)] <= curSol;
    end
  end

  a_r2_base_range: assert property (@(posedge clk) disable iff (!rstN) curBase < POOL_C);
  a_r4_sol_le_sof: assert property (@(posedge clk) disable iff (!rstN)
    (curSol <= curSof) && (curSof <= POOL_C));
  a_r6_count_pos: assert property (@(posedge clk) disable iff (!rstN)
    stb.busy |-> (memCount != '0));
  a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    stkPtr <= SPW'(STACK_DEPTH));
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  cmd_op_e       cmdOp,
  input  logic          allocOver,
  input  logic          retNeedFill,
  input  logic          stkEmpty,
  input  logic          stkFull,
  input  logic          memAck,
  output frame_strobe_t stb,
  output logic          cmdReady,
  output logic          memReq,
  output logic          memFill
);
  typedef enum logic [1:0] {S_IDLE, S_SPILL, S_FILL} state_e;
  state_e state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    stb.busy  = (state != S_IDLE);
    if (state == S_IDLE && cmdValid) begin
      unique case (cmdOp)
        OP_ALLOC: begin
          stb.alloc = 1'b1;
          if (allocOver) stateNext = S_SPILL;
        end
        OP_CALL: stb.call = !stkFull;
        OP_RET: if (!stkEmpty) begin
          if (retNeedFill) begin
            stb.retFill = 1'b1;
            stateNext   = S_FILL;
          end else begin
            stb.ret = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (state == S_SPILL && memAck) begin
      stb.spillDone = 1'b1;
      stateNext     = S_IDLE;
    end else if (state == S_FILL && memAck) begin
      stb.fillDone = 1'b1;
      stateNext    = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady = (state == S_IDLE);
  assign memReq   = (state != S_IDLE);
  assign memFill  = (state == S_FILL);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memFill)));
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (!memReq && cmdReady));
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |-> !(stb.alloc || stb.call || stb.ret || stb.retFill));
endmodule

// File: rtl/frame_mapper.sv
module frame_mapper
  import frame_pkg::*;
#(
  parameter int NUM_REGS    = 128,
  parameter int STATIC_REGS = 32,
  parameter int STACK_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [1:0]                  cmdOp,
  input  logic [$clog2(NUM_REGS)-1:0] cmdSize,
  input  logic [$clog2(NUM_REGS)-1:0] cmdOut,
  output logic                        cmdReady,
  input  logic [$clog2(NUM_REGS)-1:0] rdLogical,
  output logic [$clog2(NUM_REGS)-1:0] rdPhys,
  output logic                        rdIllegal,
  output logic                        memReq,
  output logic                        memFill,
  output logic [$clog2(NUM_REGS)-1:0] memBase,
  output logic [$clog2(NUM_REGS)-1:0] memCount,
  input  logic                        memAck
);
  frame_strobe_t stb;
  logic allocOver, retNeedFill, stkEmpty, stkFull;

  frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmd_op_e'(cmdOp)),
    .allocOver(allocOver), .retNeedFill(retNeedFill), .stkEmpty(stkEmpty),
    .stkFull(stkFull), .memAck(memAck), .stb(stb), .cmdReady(cmdReady),
    .memReq(memReq), .memFill(memFill)
  );

  frame_dp #(.NUM_REGS(NUM_REGS), .STATIC_REGS(STATIC_REGS), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdSize(cmdSize), .cmdOut(cmdOut),
    .rdLogical(rdLogical), .rdPhys(rdPhys), .rdIllegal(rdIllegal),
    .allocOver(allocOver), .retNeedFill(retNeedFill), .stkEmpty(stkEmpty),
    .stkFull(stkFull), .memBase(memBase), .memCount(memCount)
  );
endmodule

// File: tb/sim_frame_mapper.sv
module sim_frame_mapper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [6:0] cmdSize = '0, cmdOut = '0, rdLogical = '0;
  logic memAck = 1'b0;
  logic cmdReady, rdIllegal, memReq, memFill;
  logic [6:0] rdPhys, memBase, memCount;

  int checks = 0, failures = 0;
  logic probeStb = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int logical;
    int phys;
    int ill;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  frame_mapper u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSize(cmdSize),
    .cmdOut(cmdOut), .cmdReady(cmdReady), .rdLogical(rdLogical), .rdPhys(rdPhys),
    .rdIllegal(rdIllegal), .memReq(memReq), .memFill(memFill), .memBase(memBase),
    .memCount(memCount), .memAck(memAck)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected mapping per probe cycle
  always @(posedge clk) begin
    if (probeStb && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      if (!e.ill) chk($sformatf("%s phys L=%0d", e.tag, e.logical), int'(rdPhys), e.phys);
      chk($sformatf("%s illegal L=%0d", e.tag, e.logical), int'(rdIllegal), e.ill);
    end
  end

  task automatic probe(int l, int phys, int ill, string tag);
    exp_t e;
    @(negedge clk);
    rdLogical = 7'(l);
    e.logical = l; e.phys = phys; e.ill = ill; e.tag = tag;
    expQ.push_back(e);
    probeStb = 1'b1;
    @(negedge clk);
    probeStb = 1'b0;
  endtask

  task automatic cmd(int op, int size, int outc);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdSize = 7'(size); cmdOut = 7'(outc);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
  endtask

  task automatic ackMem(int fill, int base, int count, string tag);
    chk({tag, " memReq"}, int'(memReq), 1);
    chk({tag, " memFill"}, int'(memFill), fill);
    chk({tag, " memBase"}, int'(memBase), base);
    chk({tag, " memCount"}, int'(memCount), count);
    chk({tag, " cmdReady busy"}, int'(cmdReady), 0);
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    chk({tag, " memReq released"}, int'(memReq), 0);
    chk({tag, " cmdReady back"}, int'(cmdReady), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 cmdReady", int'(cmdReady), 1);
    chk("R10 memReq", int'(memReq), 0);
    probe(5, 5, 0, "R1 static");
    probe(32, 0, 1, "R3 empty frame");

    cmd(1, 20, 5);                       // window 20, locals 15, base 0
    probe(32, 32, 0, "R2 first");
    probe(51, 51, 0, "R2 last");
    probe(52, 0, 1, "R3 beyond");
    probe(31, 31, 0, "R1 top static");

    cmd(2, 0, 0);                        // base 15, size 5
    probe(32, 47, 0, "R5 overlap");
    probe(36, 51, 0, "R5 last out");
    probe(37, 0, 1, "R5 size");

    cmd(1, 60, 10);                      // locals 50
    probe(91, 106, 0, "R4 alloc");
    cmd(2, 0, 0);                        // base 65, held 65

    cmd(1, 40, 4);                       // 65+40 = 105 -> save 9
    chk("R6 memReq raised", int'(memReq), 1);
    cmd(2, 0, 0);                        // ignored while busy
    ackMem(0, 32, 9, "R6 spill");
    probe(67, 36, 0, "R2 wrap");
    probe(71, 40, 0, "R2 wrap last");
    probe(72, 0, 1, "R8 busy call ignored");

    cmd(3, 0, 0);                        // pop 60/50, held 56 -> 6
    chk("R7 no req", int'(memReq), 0);
    probe(32, 47, 0, "R7 restore");
    probe(91, 106, 0, "R7 restore size");

    cmd(3, 0, 0);                        // pop 20/15, 9 missing
    probe(32, 47, 0, "R8 hold during fill");
    ackMem(1, 32, 9, "R8 fill");
    probe(32, 32, 0, "R8 restored");
    probe(52, 0, 1, "R8 restored size");

    cmd(3, 0, 0);                        // empty stack
    chk("R9 empty ret no req", int'(memReq), 0);
    probe(32, 32, 0, "R9 empty ret");

    cmd(1, 100, 120);                    // clamp to 96, locals 0
    probe(127, 127, 0, "R4 clamp");
    cmd(2, 0, 0);                        // depth 1, base 0, size 96
    probe(127, 127, 0, "R4 out clamp");

    for (int i = 0; i < 3; i++) begin
      cmd(1, 10, 2);
      cmd(2, 0, 0);
    end                                  // depth 4, base 24
    cmd(1, 10, 2);
    cmd(2, 0, 0);                        // full: ignored
    probe(32, 56, 0, "R9 full call");
    probe(41, 65, 0, "R9 full size");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule